// File: doc/BRIEF.md
# Word-Serial Coefficient and Register Loader for a Two-Channel Image Filter

This block receives configuration for a two-channel image filter over one shared 12-bit word bus. Each channel has its own load strobe and its own pause input. A strobed transfer opens with an address word. The address picks the target storage, and with it the number of data words that follow: a coefficient set of eight coefficients, a control word, a routing word, a rounding register or a clamp register.

Data words collect in a shadow stage. The target changes in one write, and only after its last word has arrived. That write is never split across cycles, so the filter never sees a half-written set. Transfers may follow each other with no idle cycle between them. Pausing a channel freezes its place in the sequence. Dropping the strobe early throws the partial transfer away.

The filter arithmetic is not part of this block. The storage is read back through per-channel read ports: a combinational read by index for coefficient sets, rounding registers and clamp registers, and plain outputs for the control and routing words.

Top module: `filt_coef_loader`

## Requirements
- R1: While a channel is idle, its first strobed word that is not paused is an address. The 12-bit address value is decoded as follows: 0..255 select coefficient set 0..255, 256 selects the control word, 257 selects the routing word, 258..289 select rounding registers 0..31, 290..321 select clamp registers 0..31, and any larger value is unmapped.
- R2: A coefficient set takes eight data words after its address. Word k becomes coefficient k, read back at bits [12k+11:12k] of the 96-bit set. The bank entry changes on the clock edge one cycle after the edge that captures the eighth word.
- R3: The control word and the routing word each take one data word. Each is written on the same edge that captures that word.
- R4: A rounding register takes four data words. Only the low 8 bits of each word are kept, and the first word is the least significant byte of the 32-bit value. The register changes one cycle after the fourth word is captured.
- R5: A clamp register takes four data words, packed in the same way as R4. Bits [15:0] of the packed value form the lower limit and bits [31:16] form the upper limit. For example, the words 060h, 03Bh, 0A4h, 072h give a lower limit of 3B60h and an upper limit of 72A4h.
- R6: No target changes while its transfer is still incomplete.
- R7: A new address word may follow the last data word directly. The commit of the finished transfer happens in the same cycle in which that next address is accepted.
- R8: While a channel's pause is high, its strobe and the bus are ignored and its word position is held. When pause drops, loading resumes with the next data word.
- R9: A strobe-low cycle without pause abandons any partial transfer and commits nothing. The next strobed word is taken as an address.
- R10: After an unmapped address, every strobed word is discarded until the strobe drops, and nothing is written.
- R11: A channel's storage is written only through that channel's own strobe. The other channel's storage is never written.
- R12: Synchronous active-high reset clears the control, routing, rounding and clamp registers of both channels to zero and leaves both sequencers idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 2 | Per-channel load strobe |
| pause | input | 2 | Per-channel sequence hold |
| din | input | 12 | Shared address/data word bus |
| coef_raddr | input | 2x8 | Per-channel coefficient set read index |
| coef_rdata | output | 2x96 | Per-channel coefficient set read-back, coefficient k at [12k+11:12k] |
| cfg_q | output | 2x12 | Per-channel control word |
| sel_q | output | 2x12 | Per-channel routing word |
| rnd_raddr | input | 2x5 | Per-channel rounding register read index |
| rnd_rdata | output | 2x32 | Per-channel rounding register read-back |
| lim_raddr | input | 2x5 | Per-channel clamp register read index |
| lim_lo | output | 2x16 | Per-channel lower limit read-back |
| lim_hi | output | 2x16 | Per-channel upper limit read-back |

## Verification
If the word position or the address register goes wrong inside the sequencer, the fault does not show up until the transfer completes. It then appears as a wrong read-back value or a write to the wrong index, one cycle after the final word (or on the same edge for the single-word targets). Other faults show as a commit too early, where a stored value changes while a set is still partial, or as a word after a pause, an abandoned transfer or an unmapped address being taken as an address. That last case surfaces as a spurious control-word write two cycles later. The directed cases sample read-back on the exact cycles before and after each commit edge, so a one-cycle slip in the commit timing is visible.

// File: rtl/filt_ld_pkg.sv
package filt_ld_pkg;

    localparam int WORD_W    = 12;
    localparam int COEFS     = 8;
    localparam int SETS      = 256;
    localparam int RND_N     = 32;
    localparam int LIM_N     = 32;
    localparam int NCH       = 2;
    localparam int BYTE_W    = 8;
    localparam int REG_BYTES = 4;

    localparam int SET_W   = WORD_W * COEFS;
    localparam int REG_W   = BYTE_W * REG_BYTES;
    localparam int HALF_W  = REG_W / 2;
    localparam int CIDX_W  = $clog2(SETS);
    localparam int RIDX_W  = $clog2(RND_N);
    localparam int LIDX_W  = $clog2(LIM_N);
    localparam int CNT_W   = $clog2(COEFS);
    localparam int IDX_W   = CIDX_W;

    localparam int ADDR_CFG = SETS;
    localparam int ADDR_SEL = SETS + 1;
    localparam int ADDR_RND = SETS + 2;
    localparam int ADDR_LIM = ADDR_RND + RND_N;
    localparam int ADDR_END = ADDR_LIM + LIM_N;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_COEF, TGT_CFG, TGT_SEL, TGT_RND, TGT_LIM
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic                          we;
        tgt_e                          tgt;
        logic [IDX_W-1:0]              idx;
        logic [COEFS-1:0][WORD_W-1:0]  data;
    } commit_t;

    function automatic dec_t decode(input logic [WORD_W-1:0] a);
        dec_t        d;
        int unsigned v;
        v     = int'(a);
        d.tgt = TGT_NONE;
        d.idx = '0;
        if (v < SETS) begin
            d.tgt = TGT_COEF;
            d.idx = IDX_W'(v);
        end else if (v == ADDR_CFG) begin
            d.tgt = TGT_CFG;
        end else if (v == ADDR_SEL) begin
            d.tgt = TGT_SEL;
        end else if (v < ADDR_LIM) begin
            d.tgt = TGT_RND;
            d.idx = IDX_W'(v - ADDR_RND);
        end else if (v < ADDR_END) begin
            d.tgt = TGT_LIM;
            d.idx = IDX_W'(v - ADDR_LIM);
        end
        return d;
    endfunction

    function automatic int words_for(input tgt_e t);
        case (t)
            TGT_COEF:         return COEFS;
            TGT_CFG, TGT_SEL: return 1;
            TGT_RND, TGT_LIM: return REG_BYTES;
            default:          return 0;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input logic [COEFS-1:0][WORD_W-1:0] d);
        logic [REG_W-1:0] r;
        for (int b = 0; b < REG_BYTES; b++) begin
            r[b*BYTE_W +: BYTE_W] = d[b][BYTE_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/filt_ld_seq.sv
module filt_ld_seq
    import filt_ld_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld,
    input  logic                pause,
    input  logic [WORD_W-1:0]   word,
    output commit_t             cmt,
    output logic                busy_o,
    output logic [CNT_W-1:0]    pos_o
);

    logic                          busy;
    logic                          pend;
    dec_t                          dec_q;
    logic [CNT_W-1:0]              cnt;
    logic [COEFS-1:0][WORD_W-1:0]  shadow;

    logic mapped, last, single, multi, take;

    always_comb begin
        mapped = (dec_q.tgt != TGT_NONE);
        last   = mapped && (int'(cnt) == words_for(dec_q.tgt) - 1);
        single = (dec_q.tgt == TGT_CFG) || (dec_q.tgt == TGT_SEL);
        multi  = mapped && !single;
        take   = busy && ld && !pause && mapped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pend  <= 1'b0;
            cnt   <= '0;
            dec_q <= '{tgt: TGT_NONE, idx: '0};
        end else begin
            pend <= 1'b0;
            if (!pause) begin
                if (!ld) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else if (!busy) begin
                    busy  <= 1'b1;
                    cnt   <= '0;
                    dec_q <= decode(word);
                end else if (mapped) begin
                    if (last) begin
                        busy <= 1'b0;
                        cnt  <= '0;
                        pend <= multi;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) shadow[cnt] <= word;
    end

    always_comb begin
        cmt.we   = pend || (take && last && single);
        cmt.tgt  = dec_q.tgt;
        cmt.idx  = dec_q.idx;
        cmt.data = shadow;
        if (!pend) cmt.data[0] = word;
    end

    assign busy_o = busy;
    assign pos_o  = cnt;

endmodule

// File: rtl/filt_ld_store.sv
module filt_ld_store
    import filt_ld_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  commit_t            cmt,
    input  logic [CIDX_W-1:0]  coef_raddr,
    output logic [SET_W-1:0]   coef_rdata,
    output logic [WORD_W-1:0]  cfg_q,
    output logic [WORD_W-1:0]  sel_q,
    input  logic [RIDX_W-1:0]  rnd_raddr,
    output logic [REG_W-1:0]   rnd_rdata,
    input  logic [LIDX_W-1:0]  lim_raddr,
    output logic [HALF_W-1:0]  lim_lo,
    output logic [HALF_W-1:0]  lim_hi
);

    logic [SET_W-1:0] bank [SETS];
    logic [REG_W-1:0] rnd  [RND_N];
    logic [REG_W-1:0] lim  [LIM_N];
    logic [REG_W-1:0] packed_val;

    assign packed_val = pack_reg(cmt.data);

    always_ff @(posedge clk) begin
        if (cmt.we && cmt.tgt == TGT_COEF) bank[cmt.idx[CIDX_W-1:0]] <= cmt.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            sel_q <= '0;
            for (int i = 0; i < RND_N; i++) rnd[i] <= '0;
            for (int i = 0; i < LIM_N; i++) lim[i] <= '0;
        end else if (cmt.we) begin
            case (cmt.tgt)
                TGT_CFG: cfg_q <= cmt.data[0];
                TGT_SEL: sel_q <= cmt.data[0];
                TGT_RND: rnd[cmt.idx[RIDX_W-1:0]] <= packed_val;
                TGT_LIM: lim[cmt.idx[LIDX_W-1:0]] <= packed_val;
                default: ;
            endcase
        end
    end

    assign coef_rdata = bank[coef_raddr];
    assign rnd_rdata  = rnd[rnd_raddr];
    assign lim_lo     = lim[lim_raddr][HALF_W-1:0];
    assign lim_hi     = lim[lim_raddr][REG_W-1:HALF_W];

endmodule

// File: rtl/filt_coef_loader.sv
module filt_coef_loader
    import filt_ld_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NCH-1:0]               ld,
    input  logic [NCH-1:0]               pause,
    input  logic [WORD_W-1:0]            din,
    input  logic [NCH-1:0][CIDX_W-1:0]   coef_raddr,
    output logic [NCH-1:0][SET_W-1:0]    coef_rdata,
    output logic [NCH-1:0][WORD_W-1:0]   cfg_q,
    output logic [NCH-1:0][WORD_W-1:0]   sel_q,
    input  logic [NCH-1:0][RIDX_W-1:0]   rnd_raddr,
    output logic [NCH-1:0][REG_W-1:0]    rnd_rdata,
    input  logic [NCH-1:0][LIDX_W-1:0]   lim_raddr,
    output logic [NCH-1:0][HALF_W-1:0]   lim_lo,
    output logic [NCH-1:0][HALF_W-1:0]   lim_hi
);

    commit_t                   cmt [NCH];
    logic [NCH-1:0]            cmt_we;
    logic [NCH-1:0]            busy;
    logic [NCH-1:0][CNT_W-1:0] pos;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        filt_ld_seq u_seq (
            .clk    (clk),
            .rst    (rst),
            .ld     (ld[g]),
            .pause  (pause[g]),
            .word   (din),
            .cmt    (cmt[g]),
            .busy_o (busy[g]),
            .pos_o  (pos[g])
        );

        filt_ld_store u_store (
            .clk        (clk),
            .rst        (rst),
            .cmt        (cmt[g]),
            .coef_raddr (coef_raddr[g]),
            .coef_rdata (coef_rdata[g]),
            .cfg_q      (cfg_q[g]),
            .sel_q      (sel_q[g]),
            .rnd_raddr  (rnd_raddr[g]),
            .rnd_rdata  (rnd_rdata[g]),
            .lim_raddr  (lim_raddr[g]),
            .lim_lo     (lim_lo[g]),
            .lim_hi     (lim_hi[g])
        );

        assign cmt_we[g] = cmt[g].we;
    end

endmodule

// File: rtl/filt_coef_loader_chk.sv
module filt_coef_loader_chk
    import filt_ld_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [NCH-1:0]              ld,
    input logic [NCH-1:0]              pause,
    input logic [NCH-1:0][WORD_W-1:0]  cfg_q,
    input logic [NCH-1:0][WORD_W-1:0]  sel_q,
    input logic [NCH-1:0]              cmt_we,
    input logic [NCH-1:0]              busy,
    input logic [NCH-1:0][CNT_W-1:0]   pos
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R1: an accepted word while idle opens a transfer
        a_r1_addr_opens: assert property (@(posedge clk) disable iff (rst)
            (ld[c] && !pause[c] && !busy[c]) |=> busy[c]);

        // R8: pause freezes the sequence position
        a_r8_pause_holds: assert property (@(posedge clk) disable iff (rst)
            pause[c] |=> ($stable(busy[c]) && $stable(pos[c])));

        // R9: strobe low without pause returns the sequencer to idle
        a_r9_abandon: assert property (@(posedge clk) disable iff (rst)
            (!ld[c] && !pause[c]) |=> (!busy[c] && pos[c] == '0));

        // R3: control and routing words change only through a commit
        a_r3_cfg_only_on_commit: assert property (@(posedge clk) disable iff (rst)
            !$stable(cfg_q[c]) |-> $past(cmt_we[c]));
        a_r3_sel_only_on_commit: assert property (@(posedge clk) disable iff (rst)
            !$stable(sel_q[c]) |-> $past(cmt_we[c]));

        // R11: a commit needs this channel's own accepted strobe now or one cycle ago
        a_r11_commit_needs_own_strobe: assert property (@(posedge clk) disable iff (rst)
            cmt_we[c] |-> ((ld[c] && !pause[c]) || $past(ld[c] && !pause[c])));
    end

endmodule

bind filt_coef_loader filt_coef_loader_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld),
    .pause  (pause),
    .cfg_q  (cfg_q),
    .sel_q  (sel_q),
    .cmt_we (cmt_we),
    .busy   (busy),
    .pos    (pos)
);

// File: tb/tb_filt_coef_loader.sv
module tb_filt_coef_loader;
    import filt_ld_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst;
    logic [NCH-1:0]              ld;
    logic [NCH-1:0]              pause;
    logic [WORD_W-1:0]           din;
    logic [NCH-1:0][CIDX_W-1:0]  coef_raddr;
    logic [NCH-1:0][SET_W-1:0]   coef_rdata;
    logic [NCH-1:0][WORD_W-1:0]  cfg_q;
    logic [NCH-1:0][WORD_W-1:0]  sel_q;
    logic [NCH-1:0][RIDX_W-1:0]  rnd_raddr;
    logic [NCH-1:0][REG_W-1:0]   rnd_rdata;
    logic [NCH-1:0][LIDX_W-1:0]  lim_raddr;
    logic [NCH-1:0][HALF_W-1:0]  lim_lo;
    logic [NCH-1:0][HALF_W-1:0]  lim_hi;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    filt_coef_loader dut (.*);

    function automatic logic [WORD_W-1:0] cw(input int s, input int k, input int v);
        return WORD_W'(s * 37 + k * 113 + v * 291 + 5);
    endfunction

    function automatic logic [SET_W-1:0] exp_set(input int s, input int v);
        logic [SET_W-1:0] r;
        for (int k = 0; k < COEFS; k++) r[k*WORD_W +: WORD_W] = cw(s, k, v);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [SET_W-1:0] act, input logic [SET_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int ch, input logic [WORD_W-1:0] w, input bit p = 1'b0);
        ld = '0; pause = '0;
        ld[ch] = 1'b1; pause[ch] = p; din = w;
        @(negedge clk);
    endtask

    task automatic idle();
        ld = '0; pause = '0; din = '0;
        @(negedge clk);
    endtask

    task automatic load_set(input int ch, input int s, input int v);
        put(ch, WORD_W'(s));
        for (int k = 0; k < COEFS; k++) put(ch, cw(s, k, v));
    endtask

    task automatic rd_set(input int ch, input int s, output logic [SET_W-1:0] d);
        coef_raddr[ch] = CIDX_W'(s); #1; d = coef_rdata[ch];
    endtask

    task automatic rd_rnd(input int ch, input int i, output logic [REG_W-1:0] d);
        rnd_raddr[ch] = RIDX_W'(i); #1; d = rnd_rdata[ch];
    endtask

    task automatic rd_lim(input int ch, input int i, output logic [REG_W-1:0] d);
        lim_raddr[ch] = LIDX_W'(i); #1; d = {lim_hi[ch], lim_lo[ch]};
    endtask

    task automatic t_reset();
        logic [REG_W-1:0] r;
        for (int c = 0; c < NCH; c++) begin
            chk("R12 cfg after reset", SET_W'(cfg_q[c]), '0);
            chk("R12 sel after reset", SET_W'(sel_q[c]), '0);
            rd_rnd(c, 31, r); chk("R12 round after reset", SET_W'(r), '0);
            rd_lim(c, 0, r);  chk("R12 clamp after reset", SET_W'(r), '0);
        end
    endtask

    task automatic t_coef_timing();
        logic [SET_W-1:0] d;
        load_set(0, 5, 0);
        idle();
        rd_set(0, 5, d); chk("R2 set 5 first load", d, exp_set(5, 0));
        put(0, 12'd5);
        for (int k = 0; k < COEFS - 1; k++) put(0, cw(5, k, 1));
        rd_set(0, 5, d); chk("R6 set 5 unchanged after 7 words", d, exp_set(5, 0));
        put(0, cw(5, COEFS - 1, 1));
        rd_set(0, 5, d); chk("R2 set 5 not yet written at last word edge", d, exp_set(5, 0));
        idle();
        rd_set(0, 5, d); chk("R2 set 5 written one cycle later", d, exp_set(5, 1));
    endtask

    task automatic t_cfg_sel();
        put(0, 12'd256); put(0, 12'hA5C);
        chk("R3 cfg written on capture edge", SET_W'(cfg_q[0]), SET_W'(12'hA5C));
        put(0, 12'd257); put(0, 12'h3F1);
        chk("R3 sel written on capture edge", SET_W'(sel_q[0]), SET_W'(12'h3F1));
        idle();
        chk("R11 other channel cfg untouched", SET_W'(cfg_q[1]), '0);
    endtask

    task automatic t_round_limit();
        logic [REG_W-1:0] r;
        put(0, 12'd261);
        put(0, 12'hF11); put(0, 12'hE22); put(0, 12'h033); put(0, 12'h544);
        rd_rnd(0, 3, r); chk("R4 round 3 not yet written", SET_W'(r), '0);
        idle();
        rd_rnd(0, 3, r); chk("R4 round 3 low bytes packed", SET_W'(r), SET_W'(32'h44332211));
        put(0, 12'd297);
        put(0, 12'h060); put(0, 12'h03B); put(0, 12'h0A4); put(0, 12'h072);
        idle();
        rd_lim(0, 7, r); chk("R5 clamp 7 lower/upper", SET_W'(r), SET_W'(32'h72A43B60));
    endtask

    task automatic t_back_to_back();
        logic [SET_W-1:0] d;
        logic [REG_W-1:0] r;
        load_set(0, 20, 2); load_set(0, 21, 2); load_set(0, 255, 2);
        put(0, 12'd259); put(0, 12'h0AA); put(0, 12'h0BB); put(0, 12'h0CC); put(0, 12'h0DD);
        idle();
        rd_set(0, 20, d);  chk("R7 set 20 back to back", d, exp_set(20, 2));
        rd_set(0, 21, d);  chk("R7 set 21 back to back", d, exp_set(21, 2));
        rd_set(0, 255, d); chk("R1 set 255 last coefficient address", d, exp_set(255, 2));
        rd_rnd(0, 1, r);   chk("R7 round 1 after sets", SET_W'(r), SET_W'(32'hDDCCBBAA));
    endtask

    task automatic t_pause();
        logic [SET_W-1:0] d;
        put(0, 12'd40);
        for (int k = 0; k < 3; k++) put(0, cw(40, k, 3));
        put(0, 12'h100, 1'b1);
        put(0, 12'h7FF, 1'b1);
        ld = '0; pause = 2'b01; din = 12'h101; @(negedge clk);
        for (int k = 3; k < COEFS; k++) put(0, cw(40, k, 3));
        idle();
        rd_set(0, 40, d); chk("R8 paused words ignored", d, exp_set(40, 3));
    endtask

    task automatic t_abandon();
        logic [SET_W-1:0] d;
        load_set(0, 9, 4);
        put(0, 12'd9);
        for (int k = 0; k < 4; k++) put(0, cw(9, k, 5));
        idle();
        put(0, 12'd256); put(0, 12'h123);
        idle();
        rd_set(0, 9, d); chk("R9 abandoned set not committed", d, exp_set(9, 4));
        chk("R9 next word after drop is address", SET_W'(cfg_q[0]), SET_W'(12'h123));
    endtask

    task automatic t_unmapped();
        logic [REG_W-1:0] r;
        put(0, 12'd322);
        put(0, 12'd256); put(0, 12'h0AB);
        put(0, 12'd261); put(0, 12'h001); put(0, 12'h002); put(0, 12'h003); put(0, 12'h004);
        idle(); idle();
        chk("R10 cfg unchanged after unmapped", SET_W'(cfg_q[0]), SET_W'(12'h123));
        rd_rnd(0, 3, r); chk("R10 round unchanged after unmapped", SET_W'(r), SET_W'(32'h44332211));
    endtask

    task automatic t_channels();
        logic [REG_W-1:0] r;
        put(1, 12'd261); put(1, 12'h009); put(1, 12'h008); put(1, 12'h007); put(1, 12'h006);
        idle();
        rd_rnd(1, 3, r); chk("R11 channel B round 3", SET_W'(r), SET_W'(32'h06070809));
        rd_rnd(0, 3, r); chk("R11 channel A round 3 untouched", SET_W'(r), SET_W'(32'h44332211));
        chk("R11 channel B cfg still reset", SET_W'(cfg_q[1]), '0);
    endtask

    initial begin
        rst = 1'b1; ld = '0; pause = '0; din = '0;
        coef_raddr = '0; rnd_raddr = '0; lim_raddr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_coef_timing();
        t_cfg_sel();
        t_round_limit();
        t_back_to_back();
        t_pause();
        t_abandon();
        t_unmapped();
        t_channels();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule